// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block divides a 32.768 kHz oscillator clock down to a one-second tick. The divider has two stages: a first, fine stage whose output advances a second, coarse stage, and the coarse stage's countdown value is brought out as the sub-second count. Both divide ratios are programmable. The whole block runs in the oscillator clock domain, so each clock edge counts as one input pulse.

To trim the long-term rate without touching the divide ratios, a window counter steps through a repeating calibration window. The default window is 2^20 pulses, which is 32 seconds at the nominal rate. The window is split into 512 slots of 2^11 pulses. In each slot the block can drop one pulse, or add one extra. The drops are spread evenly over the window by ranking each slot with the bit-reversed slot index. A new calibration word is held in a shadow register and takes effect only when the next window begins. Writing calibration words too close together raises a pending flag.

Software writes the two divide values and the calibration word through a small register-style write port. It reads the second tick, the sub-second count and the pending flag.

Top module: `rtc_smooth_prescaler`

## Requirements
- R1: The first stage produces one output tick for every A+1 input pulses, where A is the value held in the first-stage register (write select 0, data bits [6:0]).
- R2: The second stage counts down by one on each first-stage tick. When it is at zero it reloads the value S held in the second-stage register (write select 1, data bits [14:0]), so it divides by S+1. The `subsec` output shows its current value.
- R3: `sec_tick` is high for exactly one clock, in the cycle where `subsec` has just reloaded to S.
- R4: With a calibration word of zero, the rate is set by the dividers alone. After reset the register values are A=0x7F and S=0xFF, which gives one `sec_tick` every 32768 clocks.
- R5: The calibration word is written with write select 2. Its bits [8:0] hold a drop count m in the range 0 to 511. In each window the block removes exactly m input pulses: at most one per slot, in the slots whose bit-reversed slot index is below m.
- R6: Bit 15 of the calibration word, when set, adds one extra input pulse at the start of every slot. That is 512 extra pulses per window, so the net change per window is 512 minus m.
- R7: A calibration write that arrives fewer than 3 first-stage ticks after the previous calibration write sets `cal_pending`. A write spaced further apart does not set it. Once set, the flag stays set until the next window boundary.
- R8: A written calibration word becomes active at the start of the next window. `cal_pending` clears at that same moment, unless another qualifying write arrives in the boundary cycle.
- R9: A synchronous active-high reset clears both stage counters, the window counter, the calibration state and `cal_pending`. During reset and right after it, `sec_tick` is 0 and `subsec` is 0.
- R10: A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; each rising edge is one input pulse |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Register select: 0 first stage, 1 second stage, 2 calibration, 3 unused |
| wr_data | input | 16 | Write data |
| sec_tick | output | 1 | One-clock pulse once per second |
| subsec | output | 15 | Current countdown value of the second stage |
| cal_pending | output | 1 | Set when calibration words were written too close together |

## Verification
The bound assertions check the following on every clock:
- the sub-second count steps down by exactly one on each first-stage tick;
- every second tick coincides with a reload to the programmed value and follows a first-stage tick;
- the active calibration changes only at a window boundary;
- the pending flag holds between boundaries and drops at a boundary.

Some behaviour only shows in the bench's directed scenarios, which use a shortened window:
- the exact divide ratios;
- the net pulse count gained or lost per window for several drop counts, with and without insertion;
- the spacing rule that decides whether a repeated calibration write raises the flag;
- the fact that a new word governs the window that starts as the flag falls.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  typedef enum logic [1:0] {
    SEL_FINE   = 2'd0,
    SEL_COARSE = 2'd1,
    SEL_TRIM   = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  localparam int TRIM_GAP_TICKS = 3;
endpackage

// File: rtl/rtc_fine_stage.sv
`timescale 1ns/1ps
module rtc_fine_stage #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   step,
  input  logic [W-1:0] div,
  output logic         ck_a
);
  localparam int W2 = W + 2;

  logic [W-1:0]  cnt;
  logic [W2-1:0] sum;
  logic [W2-1:0] rem;

  always_comb begin
    sum  = W2'(cnt) + W2'(step);
    ck_a = sum > W2'(div);
    rem  = sum - W2'(div) - W2'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ck_a) begin
      cnt <= (rem > W2'(div)) ? '0 : rem[W-1:0];
    end else begin
      cnt <= sum[W-1:0];
    end
  end
endmodule

// File: rtl/rtc_coarse_stage.sv
`timescale 1ns/1ps
module rtc_coarse_stage #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ck_a,
  input  logic [W-1:0] div,
  output logic [W-1:0] cnt,
  output logic         tick
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (ck_a) begin
        if (cnt == '0) begin
          cnt  <= div;
          tick <= 1'b1;
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rtc_trim_unit.sv
`timescale 1ns/1ps
module rtc_trim_unit
  import rtc_pkg::*;
#(
  parameter int WIN_BITS  = 20,
  parameter int SLOT_BITS = 11,
  localparam int MINUS_W  = WIN_BITS - SLOT_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trim_wr,
  input  logic [MINUS_W-1:0] minus_in,
  input  logic               plus_in,
  input  logic               ck_a,
  output logic [1:0]         step,
  output logic               win_wrap,
  output logic [MINUS_W-1:0] act_minus,
  output logic               act_plus,
  output logic               pending
);
  logic [WIN_BITS-1:0] win_cnt;
  logic [MINUS_W-1:0]  shd_minus;
  logic                shd_plus;
  logic [1:0]          gap;
  logic [MINUS_W-1:0]  rank;
  logic                slot_start;
  logic                drop;
  logic                add;

  always_comb begin
    for (int i = 0; i < MINUS_W; i++) begin
      rank[i] = win_cnt[WIN_BITS-1-i];
    end
    slot_start = (win_cnt[SLOT_BITS-1:0] == '0);
    drop       = slot_start && (rank < act_minus);
    add        = slot_start && act_plus;
    win_wrap   = &win_cnt;
    case ({add, drop})
      2'b10:   step = 2'd2;
      2'b01:   step = 2'd0;
      default: step = 2'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt   <= '0;
      shd_minus <= '0;
      shd_plus  <= 1'b0;
      act_minus <= '0;
      act_plus  <= 1'b0;
      pending   <= 1'b0;
      gap       <= 2'(TRIM_GAP_TICKS);
    end else begin
      win_cnt <= win_cnt + WIN_BITS'(1);
      if (win_wrap) begin
        act_minus <= shd_minus;
        act_plus  <= shd_plus;
      end
      if (trim_wr) begin
        shd_minus <= minus_in;
        shd_plus  <= plus_in;
        gap       <= '0;
      end else if (ck_a && gap != 2'(TRIM_GAP_TICKS)) begin
        gap <= gap + 2'd1;
      end
      if (trim_wr && gap != 2'(TRIM_GAP_TICKS)) begin
        pending <= 1'b1;
      end else if (win_wrap) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_smooth_prescaler.sv
`timescale 1ns/1ps
module rtc_smooth_prescaler
  import rtc_pkg::*;
#(
  parameter int          PA_W      = 7,
  parameter int          PS_W      = 15,
  parameter int          DATA_W    = 16,
  parameter int          WIN_BITS  = 20,
  parameter int          SLOT_BITS = 11,
  parameter logic [6:0]  PA_RST    = 7'h7F,
  parameter logic [14:0] PS_RST    = 15'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sec_tick,
  output logic [PS_W-1:0]   subsec,
  output logic              cal_pending
);
  localparam int MINUS_W = WIN_BITS - SLOT_BITS;

  logic [PA_W-1:0]    pa_reg;
  logic [PS_W-1:0]    ps_reg;
  logic               pa_wr;
  logic               ps_wr;
  logic               cal_wr;
  logic               ck_a;
  logic [1:0]         step;
  logic               win_wrap;
  logic [MINUS_W-1:0] act_minus;
  logic               act_plus;

  assign pa_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_FINE);
  assign ps_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_COARSE);
  assign cal_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_TRIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_reg <= PA_W'(PA_RST);
      ps_reg <= PS_W'(PS_RST);
    end else begin
      if (pa_wr) pa_reg <= wr_data[PA_W-1:0];
      if (ps_wr) ps_reg <= wr_data[PS_W-1:0];
    end
  end

  rtc_trim_unit #(
    .WIN_BITS (WIN_BITS),
    .SLOT_BITS(SLOT_BITS)
  ) i_trim (
    .clk      (clk),
    .rst      (rst),
    .trim_wr  (cal_wr),
    .minus_in (wr_data[MINUS_W-1:0]),
    .plus_in  (wr_data[DATA_W-1]),
    .ck_a     (ck_a),
    .step     (step),
    .win_wrap (win_wrap),
    .act_minus(act_minus),
    .act_plus (act_plus),
    .pending  (cal_pending)
  );

  rtc_fine_stage #(.W(PA_W)) i_fine (
    .clk (clk),
    .rst (rst),
    .step(step),
    .div (pa_reg),
    .ck_a(ck_a)
  );

  rtc_coarse_stage #(.W(PS_W)) i_coarse (
    .clk (clk),
    .rst (rst),
    .ck_a(ck_a),
    .div (ps_reg),
    .cnt (subsec),
    .tick(sec_tick)
  );
endmodule

// File: rtl/rtc_smooth_prescaler_chk.sv
`timescale 1ns/1ps
module rtc_smooth_prescaler_chk #(
  parameter int PS_W    = 15,
  parameter int MINUS_W = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               sec_tick,
  input logic [PS_W-1:0]    subsec,
  input logic [PS_W-1:0]    ps_reg,
  input logic               ps_wr,
  input logic               ck_a,
  input logic               cal_pending,
  input logic               win_wrap,
  input logic               cal_wr,
  input logic [MINUS_W-1:0] act_minus,
  input logic               act_plus
);
  AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (rst)
    sec_tick && !$past(ps_wr) |-> subsec == ps_reg); // R3

  AST_TICK_AFTER_FINE: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> $past(ck_a)); // R3

  AST_SUBSEC_DOWN: assert property (@(posedge clk) disable iff (rst)
    ck_a && subsec != '0 |=> subsec == PS_W'($past(subsec) - PS_W'(1))); // R2

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    cal_pending && !win_wrap |=> cal_pending); // R7

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    win_wrap && !cal_wr |=> !cal_pending); // R8

  AST_TRIM_STABLE: assert property (@(posedge clk) disable iff (rst)
    !win_wrap |=> $stable(act_minus) && $stable(act_plus)); // R8
endmodule

bind rtc_smooth_prescaler rtc_smooth_prescaler_chk #(
  .PS_W   (PS_W),
  .MINUS_W(MINUS_W)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .sec_tick   (sec_tick),
  .subsec     (subsec),
  .ps_reg     (ps_reg),
  .ps_wr      (ps_wr),
  .ck_a       (ck_a),
  .cal_pending(cal_pending),
  .win_wrap   (win_wrap),
  .cal_wr     (cal_wr),
  .act_minus  (act_minus),
  .act_plus   (act_plus)
);

// File: tb/test_rtc_smooth_prescaler.sv
`timescale 1ns/1ps
module test_rtc_smooth_prescaler;
  localparam int WINB  = 12;
  localparam int SLOTB = 3;
  localparam int WIN   = 1 << WINB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        sec_tick;
  logic [14:0] subsec;
  logic        cal_pending;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  rtc_smooth_prescaler #(
    .WIN_BITS (WINB),
    .SLOT_BITS(SLOTB)
  ) i_rtc_smooth_prescaler (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .sec_tick   (sec_tick),
    .subsec     (subsec),
    .cal_pending(cal_pending)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!sec_tick);
  endtask

  task automatic period(output int n);
    wait_tick();
    n = 0;
    do begin @(negedge clk); n++; end while (!sec_tick);
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sec_tick) n++;
    end
  endtask

  task automatic t_reset();
    int p;
    repeat (3) @(negedge clk);
    chk(sec_tick == 1'b0 && subsec == 15'd0, "R9 outputs in reset", int'(subsec), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(subsec == 15'd0, "R9 subsec after reset", int'(subsec), 0);
    chk(sec_tick == 1'b0, "R9 tick after reset", int'(sec_tick), 0);
    chk(cal_pending == 1'b0, "R9 pending after reset", int'(cal_pending), 0);
    period(p);
    chk(p == 32768, "R4 default one-second period", p, 32768);
  endtask

  task automatic t_dividers();
    int p;
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd4);
    wait_tick();
    chk(subsec == 15'd4, "R3 subsec reloaded on tick", int'(subsec), 4);
    @(negedge clk);
    chk(sec_tick == 1'b0, "R3 tick lasts one clock", int'(sec_tick), 0);
    period(p);
    chk(p == 20, "R1 R2 period 4x5", p, 20);
    period(p);
    chk(p == 20, "R2 repeated period", p, 20);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd9);
    period(p); period(p);
    chk(p == 10, "R2 divide by S+1 with A=0", p, 10);
    wr(2'd0, 16'd7);
    wr(2'd1, 16'd0);
    period(p); period(p);
    chk(p == 8, "R1 divide by A+1 with S=0", p, 8);
  endtask

  task automatic t_ignored();
    int p;
    wr(2'd3, 16'h0000);
    period(p);
    chk(p == 8, "R10 select 3 has no effect", p, 8);
  endtask

  task automatic t_cal(input int m, input bit plus, input string req);
    int n, e;
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd0);
    wr(2'd2, {plus, 6'd0, 9'(m)});
    repeat (WIN + 10) @(negedge clk);
    count_ticks(2 * WIN, n);
    e = WIN + (plus ? 512 : 0) - m;
    chk(n >= e - 1 && n <= e + 1, req, n, e);
  endtask

  task automatic t_pending();
    int n, e;
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd0);
    repeat (WIN + 10) @(negedge clk);
    chk(cal_pending == 1'b0, "R8 pending clear after boundary", int'(cal_pending), 0);
    wr(2'd2, 16'd50);
    repeat (20) @(negedge clk);
    wr(2'd2, 16'd60);
    chk(cal_pending == 1'b0, "R7 spaced writes leave flag low", int'(cal_pending), 0);
    wr(2'd2, 16'd400);
    chk(cal_pending == 1'b1, "R7 close write raises flag", int'(cal_pending), 1);
    n = 0;
    while (cal_pending && n < WIN + 10) begin @(negedge clk); n++; end
    chk(n >= 1 && n <= WIN, "R8 flag clears at next boundary", n, WIN);
    count_ticks(WIN, n);
    e = WIN / 2 - 200;
    chk(n >= e - 1 && n <= e + 1, "R8 new word governs next window", n, e);
  endtask

  initial begin
    t_reset();
    t_dividers();
    t_ignored();
    t_cal(0, 1'b0, "R4 zero trim keeps rate");
    t_cal(100, 1'b0, "R5 drop 100 per window");
    t_cal(511, 1'b0, "R5 drop 511 per window");
    t_cal(0, 1'b1, "R6 insert 512 per window");
    t_cal(300, 1'b1, "R5 R6 insert with drop 300");
    t_pending();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule